// File: doc/BRIEF.md
# ADC Auto-Sequencing Conversion Controller

This block runs a 12-bit analog-to-digital converter through a programmed list of conversions. Software fills a table of sequence slots. Each slot holds the number of one of 16 analog inputs. The controller walks the slots in order. For each slot it sets the multiplexer channel select, waits a programmable settle time, and pulses start-of-conversion. It then waits for the converter's done strobe and stores the returned sample in the result register that belongs to that slot.

Channels may appear in any order and any number of times. The storage is indexed by slot position, not by channel number, so the same channel can fill several results in one sequence. A continuous mode re-runs the table without further start pulses. The result registers are read back through a one-cycle registered read port.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `conv_soc` and `seq_done` are low, `chan_sel` is 0, and no conversion is started until a `start` pulse arrives.
- R2: A configuration write to address k (0..15) sets the channel of slot k from `cfg_wdata[3:0]`. The conversion of slot k is started with `chan_sel` equal to that channel, and its sample is stored in result register k.
- R3: A write to address 16 sets the sequence length from `cfg_wdata[3:0]`: field value plus one slots, from 1 to 16, converted from slot 0 upward.
- R4: A channel that appears in several slots is converted once for each of those slots, and each of its samples lands in its own slot's result.
- R5: Setting `rd_slot` to n presents result register n on `rd_data` one clock later.
- R6: `conv_soc` is a single-cycle pulse. A conversion is never started while the previous one is still waiting for `conv_done`.
- R7: When `conv_done` arrives for the last programmed slot, `seq_done` pulses high for exactly one cycle. Without continuous mode, the controller then stays idle.
- R8: A `start` pulse that arrives while a sequence is running has no effect: the sequence keeps its length and produces only one `seq_done`.
- R9: Result registers of slots at or beyond the programmed length keep their earlier contents when a shorter sequence runs.
- R10: While bit 4 of the address-16 word (continuous mode) is set, each completed sequence restarts at slot 0 without a `start` pulse. Once the bit is cleared, the controller goes idle after the sequence in progress finishes.
- R11: Bits 15:8 of the address-16 word give a settle count S. The first `conv_soc` of a sequence is seen S+2 cycles after the `start` pulse is applied, and each later slot waits the same S extra cycles after its channel select changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration address: 0..15 slot channels, 16 control word |
| cfg_wdata | input | 16 | Configuration write data |
| start | input | 1 | Begins a sequence when idle |
| conv_soc | output | 1 | Start-of-conversion pulse to the converter |
| conv_done | input | 1 | Converter reports a finished conversion |
| conv_data | input | 12 | Converter sample, valid with `conv_done` |
| chan_sel | output | 4 | Channel select to the analog multiplexer |
| rd_slot | input | 4 | Result register to read |
| rd_data | output | 12 | Registered read of the selected result |
| seq_done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
The assertions assume three things about the inputs. The sequence length and slot table are left unchanged while a sequence runs. The converter returns exactly one `conv_done` for each `conv_soc`. That `conv_done` arrives only after the pulse has dropped. The bench's converter model meets all three. It answers each start pulse once, after a random latency of zero to four cycles. The bench writes slot channels, length and settle count only while the controller is idle. The one configuration write made during a run clears the continuous bit, which the controller reads only at the end of a sequence.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_WAIT   = 2'd2
  } seq_state_t;

  // bit of the control word where the settle count starts
  localparam int SETTLE_LSB = 8;

endpackage

// File: rtl/adc_seq_cfg.sv
`timescale 1ns/1ps
module adc_seq_cfg #(
  parameter int N_SLOTS  = 16,
  parameter int CH_W     = 4,
  parameter int SETTLE_W = 8,
  parameter int CFG_W    = 16,
  localparam int SLOT_W  = $clog2(N_SLOTS),
  localparam int ADDR_W  = $clog2(N_SLOTS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [CH_W-1:0]     slot_ch [N_SLOTS],
  output logic [SLOT_W-1:0]   len_m1,
  output logic                cont,
  output logic [SETTLE_W-1:0] settle
);
  import adc_seq_pkg::*;

  localparam int CONT_BIT = SLOT_W;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(N_SLOTS);

  logic ctrl_we;
  assign ctrl_we = cfg_we && (cfg_addr == CTRL_ADDR);

  // one channel register per slot
  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    logic slot_we;
    assign slot_we = cfg_we && (cfg_addr == ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (rst)          slot_ch[g] <= '0;
      else if (slot_we) slot_ch[g] <= cfg_wdata[CH_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_m1 <= '0;
      cont   <= 1'b0;
      settle <= '0;
    end else if (ctrl_we) begin
      len_m1 <= cfg_wdata[SLOT_W-1:0];
      cont   <= cfg_wdata[CONT_BIT];
      settle <= cfg_wdata[SETTLE_LSB +: SETTLE_W];
    end
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl_we) |-> $stable(len_m1)) else $error("length changed without write"); // R3

endmodule

// File: rtl/adc_seq_fsm.sv
`timescale 1ns/1ps
module adc_seq_fsm #(
  parameter int N_SLOTS  = 16,
  parameter int CH_W     = 4,
  parameter int DATA_W   = 12,
  parameter int SETTLE_W = 8,
  localparam int SLOT_W  = $clog2(N_SLOTS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                conv_done,
  input  logic [DATA_W-1:0]   conv_data,
  input  logic [CH_W-1:0]     slot_ch [N_SLOTS],
  input  logic [SLOT_W-1:0]   len_m1,
  input  logic                cont,
  input  logic [SETTLE_W-1:0] settle,
  output logic                conv_soc,
  output logic [CH_W-1:0]     chan_sel,
  output logic                seq_done,
  output logic                wr_en,
  output logic [SLOT_W-1:0]   wr_addr,
  output logic [DATA_W-1:0]   wr_data
);
  import adc_seq_pkg::*;

  seq_state_t          state;
  logic [SLOT_W-1:0]   slot;
  logic [SLOT_W-1:0]   slot_nxt;
  logic [SETTLE_W-1:0] cnt;
  logic                take;
  logic                last;

  assign slot_nxt = slot + 1'b1;
  assign take     = (state == ST_WAIT) && conv_done;
  assign last     = (slot == len_m1);

  // result write goes straight to the storage in the done cycle
  assign wr_en   = take;
  assign wr_addr = slot;
  assign wr_data = conv_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      slot     <= '0;
      cnt      <= '0;
      chan_sel <= '0;
      conv_soc <= 1'b0;
      seq_done <= 1'b0;
    end else begin
      conv_soc <= 1'b0;
      seq_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            slot     <= '0;
            chan_sel <= slot_ch[0];
            cnt      <= settle;
            state    <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (cnt == '0) begin
            conv_soc <= 1'b1;
            state    <= ST_WAIT;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WAIT: begin
          if (conv_done) begin
            if (last) begin
              seq_done <= 1'b1;
              if (cont) begin
                slot     <= '0;
                chan_sel <= slot_ch[0];
                cnt      <= settle;
                state    <= ST_SETTLE;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              slot     <= slot_nxt;
              chan_sel <= slot_ch[slot_nxt];
              cnt      <= settle;
              state    <= ST_SETTLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SOC_PULSE: assert property (@(posedge clk) disable iff (rst)
    conv_soc |=> !conv_soc) else $error("start pulse longer than one cycle"); // R6
  AST_SOC_CH_STABLE: assert property (@(posedge clk) disable iff (rst)
    conv_soc |-> $stable(chan_sel)) else $error("channel moved at conversion start"); // R2
  AST_SOC_NOT_WAITING: assert property (@(posedge clk) disable iff (rst)
    conv_soc |-> !$past(state == ST_WAIT)) else $error("conversion started while waiting"); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done) else $error("sequence done longer than one cycle"); // R7
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> $past(conv_done)) else $error("sequence done without converter done"); // R7
  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (slot <= len_m1)) else $error("slot beyond length"); // R3

endmodule

// File: rtl/adc_seq_results.sv
`timescale 1ns/1ps
module adc_seq_results #(
  parameter int N_SLOTS = 16,
  parameter int DATA_W  = 12,
  localparam int SLOT_W = $clog2(N_SLOTS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SLOT_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  // one write port, one registered read port, no reset: maps to block RAM
  logic [DATA_W-1:0] mem [N_SLOTS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl #(
  parameter int N_SLOTS  = 16,
  parameter int CH_W     = 4,
  parameter int DATA_W   = 12,
  parameter int SETTLE_W = 8,
  parameter int CFG_W    = 16,
  localparam int SLOT_W  = $clog2(N_SLOTS),
  localparam int ADDR_W  = $clog2(N_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              start,
  output logic              conv_soc,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic [CH_W-1:0]   chan_sel,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [DATA_W-1:0] rd_data,
  output logic              seq_done
);
  logic [CH_W-1:0]     slot_ch [N_SLOTS];
  logic [SLOT_W-1:0]   len_m1;
  logic                cont;
  logic [SETTLE_W-1:0] settle;
  logic                wr_en;
  logic [SLOT_W-1:0]   wr_addr;
  logic [DATA_W-1:0]   wr_data;

  adc_seq_cfg #(
    .N_SLOTS(N_SLOTS), .CH_W(CH_W), .SETTLE_W(SETTLE_W), .CFG_W(CFG_W)
  ) cfg_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .slot_ch(slot_ch), .len_m1(len_m1),
    .cont(cont), .settle(settle)
  );

  adc_seq_fsm #(
    .N_SLOTS(N_SLOTS), .CH_W(CH_W), .DATA_W(DATA_W), .SETTLE_W(SETTLE_W)
  ) fsm_i (
    .clk(clk), .rst(rst), .start(start), .conv_done(conv_done),
    .conv_data(conv_data), .slot_ch(slot_ch), .len_m1(len_m1),
    .cont(cont), .settle(settle), .conv_soc(conv_soc), .chan_sel(chan_sel),
    .seq_done(seq_done), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  adc_seq_results #(
    .N_SLOTS(N_SLOTS), .DATA_W(DATA_W)
  ) res_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_slot), .rd_data(rd_data)
  );

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> (!conv_soc && !seq_done)) else $error("activity right after reset"); // R1

endmodule

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        start = 1'b0;
  logic        conv_soc;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic [3:0]  chan_sel;
  logic [3:0]  rd_slot = '0;
  logic [11:0] rd_data;
  logic        seq_done;

  always #2.5 clk = ~clk;

  adc_seq_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start(start), .conv_soc(conv_soc),
    .conv_done(conv_done), .conv_data(conv_data), .chan_sel(chan_sel),
    .rd_slot(rd_slot), .rd_data(rd_data), .seq_done(seq_done)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // bench copy of what software programmed
  int tbl [16];
  int exp_res [16];
  bit exp_ok [16];

  // converter model log
  int soc_ch [1024];
  int soc_dat [1024];
  int soc_n = 0;
  int done_n = 0;
  int tag = 0;
  bit pend = 1'b0;
  int pend_cnt = 0;
  int pend_dat = 0;

  always @(negedge clk) begin
    conv_done = 1'b0;
    if (pend) begin
      if (pend_cnt == 0) begin
        conv_done = 1'b1;
        conv_data = 12'(pend_dat);
        pend = 1'b0;
      end else begin
        pend_cnt--;
      end
    end
    if (conv_soc) begin
      pend = 1'b1;
      pend_cnt = int'($urandom_range(4, 0));
      tag = (tag + 1) % 256;
      pend_dat = (int'(chan_sel) << 8) | tag;
      if (soc_n < 1024) begin
        soc_ch[soc_n] = int'(chan_sel);
        soc_dat[soc_n] = pend_dat;
      end
      soc_n++;
    end
    if (seq_done) done_n++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic cfg_write(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = 5'(addr);
    cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_ctrl(input int len, input bit cont, input int settle);
    cfg_write(16, (settle << 8) | (int'(cont) << 4) | (len - 1));
  endtask

  task automatic set_slot(input int k, input int ch);
    tbl[k] = ch;
    cfg_write(k, ch);
  endtask

  task automatic read_res(input int k, output int v);
    @(negedge clk);
    rd_slot = 4'(k);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic check_results(input string req);
    for (int k = 0; k < 16; k++) begin
      if (exp_ok[k]) begin
        int v;
        read_res(k, v);
        chk(v == exp_res[k], req, $sformatf("result slot %0d", k), v, exp_res[k]);
      end
    end
  endtask

  // runs one sequence; channel table and control word already written
  task automatic run_seq(input int len, input int settle, input bit busy_start);
    int d;
    int t;
    @(negedge clk);
    soc_n = 0;
    done_n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    d = 1;
    while (!conv_soc && d < 400) begin
      @(negedge clk);
      d++;
    end
    chk(d == settle + 2, "R11", "cycles from start to first soc", d, settle + 2);
    if (busy_start) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!seq_done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(seq_done == 1'b1, "R7", "seq_done seen", int'(seq_done), 1);
    @(negedge clk);
    chk(seq_done == 1'b0, "R7", "seq_done width", int'(seq_done), 0);
    repeat (settle + 20) @(negedge clk);
    chk(soc_n == len, busy_start ? "R8" : "R3", "conversions in sequence", soc_n, len);
    chk(done_n == 1, busy_start ? "R8" : "R7", "seq_done pulses", done_n, 1);
    for (int k = 0; k < len && k < soc_n; k++) begin
      chk(soc_ch[k] == tbl[k], "R2", $sformatf("channel at slot %0d", k), soc_ch[k], tbl[k]);
      exp_res[k] = soc_dat[k];
      exp_ok[k] = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int s;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 16; k++) begin
      tbl[k] = 0;
      exp_ok[k] = 1'b0;
      exp_res[k] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state, no activity without start
    chk(conv_soc == 1'b0, "R1", "conv_soc after reset", int'(conv_soc), 0);
    chk(seq_done == 1'b0, "R1", "seq_done after reset", int'(seq_done), 0);
    chk(chan_sel == 4'd0, "R1", "chan_sel after reset", int'(chan_sel), 0);
    repeat (20) @(negedge clk);
    chk(soc_n == 0, "R1", "conversions without start", soc_n, 0);

    // R2 R5 R6: full table, reversed channels, no settle
    for (int k = 0; k < 16; k++) set_slot(k, 15 - k);
    set_ctrl(16, 1'b0, 0);
    run_seq(16, 0, 1'b0);
    check_results("R5");

    // R4 R9 R11: one channel repeated, shorter sequence, settle 3
    for (int k = 0; k < 4; k++) set_slot(k, 5);
    set_ctrl(4, 1'b0, 3);
    run_seq(4, 3, 1'b0);
    chk(soc_dat[0] != soc_dat[3], "R4", "repeated channel gives fresh samples",
        soc_dat[3], soc_dat[0] + 1);
    check_results("R9");

    // R3: shortest sequence
    set_slot(0, 9);
    set_ctrl(1, 1'b0, 0);
    run_seq(1, 0, 1'b0);
    check_results("R3");

    // R8: start pulse while running
    for (int k = 0; k < 3; k++) set_slot(k, k + 2);
    set_ctrl(3, 1'b0, 10);
    run_seq(3, 10, 1'b1);
    check_results("R8");

    // random sequences
    for (int r = 0; r < 8; r++) begin
      int len;
      len = int'($urandom_range(16, 1));
      s = int'($urandom_range(6, 0));
      for (int k = 0; k < len; k++) set_slot(k, int'($urandom_range(15, 0)));
      set_ctrl(len, 1'b0, s);
      run_seq(len, s, 1'b0);
      check_results("R2");
    end

    // R10: continuous mode
    set_slot(0, 7);
    set_slot(1, 12);
    set_ctrl(2, 1'b1, 1);
    @(negedge clk);
    soc_n = 0;
    done_n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    s = 0;
    while (done_n < 3 && s < 3000) begin
      @(negedge clk);
      s++;
    end
    chk(done_n >= 3, "R10", "automatic restarts", done_n, 3);
    set_ctrl(2, 1'b0, 1);
    repeat (300) @(negedge clk);
    s = soc_n;
    repeat (200) @(negedge clk);
    chk(soc_n == s, "R10", "stops after clearing continuous", soc_n, s);
    chk(soc_n == 2 * done_n, "R10", "conversions per completed sequence", soc_n, 2 * done_n);
    for (int k = 0; k < soc_n && k < 1024; k++) begin
      if (soc_ch[k] != tbl[k % 2])
        chk(1'b0, "R10", $sformatf("channel at conversion %0d", k), soc_ch[k], tbl[k % 2]);
    end
    n_chk++;
    if (soc_n >= 2) begin
      exp_res[0] = soc_dat[soc_n - 2];
      exp_res[1] = soc_dat[soc_n - 1];
    end
    check_results("R10");

    finish_run();
  end

endmodule